// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the hardwired control unit and register file of a small accumulator-style processor. A four-state phase machine moves through instruction fetch, optional operand-address indirection, execution and interrupt entry. Each phase is cut into numbered steps, and every step performs a fixed set of register transfers. The block holds the program counter, the memory address and memory buffer registers, the instruction register and one general register. It talks to a single-ported synchronous memory through an address bus, a write-data bus, a read-data bus and separate read and write strobes.

An instruction is a 16-bit word. Bit 15 asks for indirection, bits 14:12 hold the opcode (001 add memory to the general register, 010 increment memory and skip when the result is zero, 011 store the return address and branch, every other code a no-op), and bits 11:0 hold the address. A single interrupt request is honoured at the end of an execute phase while interrupts are enabled. Interrupt entry writes the return address to word 0, continues at word 1 and disables further interrupts until the next reset.

The phase states are FETCH (code 00), INDIRECT (01), EXECUTE (10) and INTERRUPT (11). The transitions are: FETCH to INDIRECT when the fetched word has bit 15 set, otherwise FETCH to EXECUTE; INDIRECT to EXECUTE; EXECUTE to INTERRUPT when a request is present and interrupts are enabled, otherwise EXECUTE to FETCH; INTERRUPT to FETCH. A phase is left only from its last step.

Top module: `isc_top`

## Requirements
- R1: Reset clears the program counter and the general register, and the block starts in FETCH (cycle code 00) at step index 0 with interrupts enabled.
- R2: The cycle code follows only the transitions FETCH to INDIRECT or EXECUTE, INDIRECT to EXECUTE, EXECUTE to FETCH or INTERRUPT, and INTERRUPT to FETCH, with codes 00, 01, 10 and 11.
- R3: FETCH takes 3 cycles. It reads the word at the program counter, increments the program counter by one and loads the instruction register.
- R4: A fetched word with bit 15 set enters INDIRECT for 3 cycles. The address field is replaced by bits 11:0 of the memory word it points to. A word with bit 15 clear skips INDIRECT.
- R5: Opcode 001 takes 3 execute cycles and adds the 16-bit memory operand to the general register, modulo 2^16.
- R6: Opcode 010 takes 4 execute cycles. It writes the operand plus one back to the same address and increments the program counter once more when the written value is zero.
- R7: Opcode 011 takes 3 execute cycles. It writes the zero-extended program counter of the next instruction to the operand address and continues at the operand address plus one.
- R8: Opcodes 000 and 100 through 111 take 1 execute cycle and change no register or memory word.
- R9: A request present at the last execute step while interrupts are enabled enters INTERRUPT for 3 cycles. It writes the zero-extended program counter to word 0, sets the program counter to 1 and disables interrupts, so that later requests are ignored until reset.
- R10: A read presents its address with the read strobe high, and the data is taken one cycle later. The read and write strobes are never high together.
- R11: The step index returns to 0 on every change of cycle code and otherwise counts up by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, registered by the memory |
| cyc_code | output | 2 | Current phase code |
| step_idx | output | 2 | Step index inside the current phase |
| pc_out | output | 12 | Program counter |
| r1_out | output | 16 | General register |

## Verification
A wrong phase or step register shows on cyc_code and step_idx in the very cycle it goes wrong, and it also shows as an instruction taking the wrong number of cycles before the next FETCH step 0. A wrong memory-buffer or address register shows first as a wrong mem_addr or mem_wdata on the following strobe, and then as a program counter or general register value that disagrees with an instruction-level model at the next instruction boundary. A lost or wrong write may stay hidden until the word is read again, so the final memory image is compared against the model at the end of every run.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        OPK_NOP,
        OPK_ADD,
        OPK_ISZ,
        OPK_BSA
    } opk_e;

    localparam int STEP_W = 2;
    localparam int OPC_W  = 3;

    localparam logic [OPC_W-1:0] OPC_ADD = 3'b001;
    localparam logic [OPC_W-1:0] OPC_ISZ = 3'b010;
    localparam logic [OPC_W-1:0] OPC_BSA = 3'b011;

    localparam logic [STEP_W-1:0] LAST_FIXED = 2'd2;

endpackage

// File: rtl/isc_decode.sv
module isc_decode
    import isc_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    output opk_e              kind,
    output logic [STEP_W-1:0] exec_last
);

    always_comb begin
        unique case (opc)
            OPC_ADD: kind = OPK_ADD;
            OPC_ISZ: kind = OPK_ISZ;
            OPC_BSA: kind = OPK_BSA;
            default: kind = OPK_NOP;
        endcase
    end

    always_comb begin
        unique case (kind)
            OPK_NOP: exec_last = 2'd0;
            OPK_ADD: exec_last = 2'd2;
            OPK_ISZ: exec_last = 2'd3;
            OPK_BSA: exec_last = 2'd2;
        endcase
    end

endmodule

// File: rtl/isc_phase_fsm.sv
module isc_phase_fsm
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic              fetch_ind,
    input  logic [STEP_W-1:0] exec_last,
    output cyc_e              phase,
    output logic [STEP_W-1:0] step
);

    cyc_e              phase_nxt;
    logic              int_en;
    logic [STEP_W-1:0] last_step;
    logic              at_last;

    always_comb begin
        last_step = (phase == CYC_EXEC) ? exec_last : LAST_FIXED;
        at_last   = (step == last_step);
        phase_nxt = phase;
        if (at_last) begin
            unique case (phase)
                CYC_FETCH: phase_nxt = fetch_ind ? CYC_INDIR : CYC_EXEC;
                CYC_INDIR: phase_nxt = CYC_EXEC;
                CYC_EXEC:  phase_nxt = (irq && int_en) ? CYC_INTR : CYC_FETCH;
                CYC_INTR:  phase_nxt = CYC_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= CYC_FETCH;
            step   <= '0;
            int_en <= 1'b1;
        end else begin
            phase <= phase_nxt;
            step  <= at_last ? '0 : step + 1'b1;
            if (at_last && phase_nxt == CYC_INTR)
                int_en <= 1'b0;
        end
    end

    // R11: a phase change always lands on step 0
    a_r11_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (step == '0));

    // R11: inside a phase the step counts up by one
    a_r11_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == $past(phase) && step != '0) |-> (step == $past(step) + 1'b1));

    // R2: fetch never goes directly to interrupt
    a_r2_fetch_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == CYC_FETCH && phase != CYC_FETCH) |-> (phase != CYC_INTR));

    // R2: interrupt entry is followed by fetch
    a_r2_intr_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == CYC_INTR && phase != CYC_INTR) |-> (phase == CYC_FETCH));

    // R9: once an interrupt was taken, no second one before reset
    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CYC_INTR && $past(phase) != CYC_INTR) |-> $past(int_en));

endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
    import isc_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              phase,
    input  logic [STEP_W-1:0] step,
    input  opk_e              kind,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opc,
    output logic              fetch_ind,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] r1
);

    localparam int IR_W = ADDR_W + OPC_W;
    localparam int PAD  = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [IR_W-1:0]   ir;
    logic [ADDR_W-1:0] ir_addr;
    logic [DATA_W-1:0] pc_ext;
    logic              opnd_rd;

    assign ir_addr   = ir[ADDR_W-1:0];
    assign opc       = ir[IR_W-1 -: OPC_W];
    assign pc_ext    = {{PAD{1'b0}}, pc};
    assign fetch_ind = mbr[DATA_W-1];
    assign mem_wdata = mbr;

    // memory port: address is sent in the same step as the MAR load
    always_comb begin
        opnd_rd = (phase == CYC_EXEC) && (step == 2'd0) &&
                  (kind == OPK_ADD || kind == OPK_ISZ);
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        mem_addr = mar;
        if (phase == CYC_FETCH && step == 2'd0) begin
            mem_rd   = 1'b1;
            mem_addr = pc;
        end else if ((phase == CYC_INDIR && step == 2'd0) || opnd_rd) begin
            mem_rd   = 1'b1;
            mem_addr = ir_addr;
        end else if ((phase == CYC_INTR && step == 2'd2) ||
                     (phase == CYC_EXEC && kind == OPK_ISZ && step == 2'd3) ||
                     (phase == CYC_EXEC && kind == OPK_BSA && step == 2'd1)) begin
            mem_wr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            r1  <= '0;
        end else begin
            unique case (phase)
                CYC_FETCH: begin
                    unique case (step)
                        2'd0: mar <= pc;
                        2'd1: begin
                            mbr <= mem_rdata;
                            pc  <= pc + 1'b1;
                        end
                        2'd2: ir <= mbr[IR_W-1:0];
                        default: ;
                    endcase
                end
                CYC_INDIR: begin
                    unique case (step)
                        2'd0: mar <= ir_addr;
                        2'd1: mbr <= mem_rdata;
                        2'd2: ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
                        default: ;
                    endcase
                end
                CYC_INTR: begin
                    unique case (step)
                        2'd0: mbr <= pc_ext;
                        2'd1: begin
                            mar <= SAVE_ADDR;
                            pc  <= VEC_ADDR;
                        end
                        default: ;
                    endcase
                end
                CYC_EXEC: begin
                    unique case (kind)
                        OPK_ADD: begin
                            unique case (step)
                                2'd0: mar <= ir_addr;
                                2'd1: mbr <= mem_rdata;
                                2'd2: r1  <= r1 + mbr;
                                default: ;
                            endcase
                        end
                        OPK_ISZ: begin
                            unique case (step)
                                2'd0: mar <= ir_addr;
                                2'd1: mbr <= mem_rdata;
                                2'd2: mbr <= mbr + 1'b1;
                                2'd3: if (mbr == '0) pc <= pc + 1'b1;
                            endcase
                        end
                        OPK_BSA: begin
                            unique case (step)
                                2'd0: begin
                                    mar <= ir_addr;
                                    mbr <= pc_ext;
                                end
                                2'd1: pc <= ir_addr;
                                2'd2: pc <= pc + 1'b1;
                                default: ;
                            endcase
                        end
                        OPK_NOP: ;
                    endcase
                end
            endcase
        end
    end

    // R10: one strobe at a time
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3: the fetch read uses the program counter value seen next step minus one
    a_r3_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CYC_FETCH && step == 2'd1) |=> (pc == $past(pc) + 1'b1));

    // R9: the save write goes to the save address and holds the return point
    a_r9_save_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CYC_INTR && step == 2'd2) |-> (mem_wr && mem_addr == SAVE_ADDR));

    // R8: a no-op execute leaves the general register alone
    a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == CYC_EXEC && kind == OPK_NOP) |=> (r1 == $past(r1) && pc == $past(pc)));

    // R10: the data of a read is consumed in the step right after the strobe
    a_r10_read_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && phase != CYC_FETCH) |=> (step == 2'd1));

endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        cyc_code,
    output logic [STEP_W-1:0] step_idx,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] r1_out
);

    cyc_e              phase;
    logic [STEP_W-1:0] step;
    opk_e              kind;
    logic [STEP_W-1:0] exec_last;
    logic [OPC_W-1:0]  opc;
    logic              fetch_ind;

    isc_decode u_decode (
        .opc       (opc),
        .kind      (kind),
        .exec_last (exec_last)
    );

    isc_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .fetch_ind (fetch_ind),
        .exec_last (exec_last),
        .phase     (phase),
        .step      (step)
    );

    isc_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .step      (step),
        .kind      (kind),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .opc       (opc),
        .fetch_ind (fetch_ind),
        .pc        (pc_out),
        .r1        (r1_out)
    );

    assign cyc_code = phase;
    assign step_idx = step;

endmodule

// File: tb/isc_top_tb.sv
module isc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  cyc_code;
    logic [1:0]  step_idx;
    logic [11:0] pc_out;
    logic [15:0] r1_out;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] mem [0:4095];
    logic [15:0] mm  [0:4095];
    logic [11:0] mpc;
    logic [15:0] mr1;
    bit          mie;

    always #2 clk = ~clk;

    isc_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cyc_code(cyc_code), .step_idx(step_idx),
        .pc_out(pc_out), .r1_out(r1_out)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] d);
        mem[a] = d;
        mm[a]  = d;
    endtask

    // instruction-level reference model
    task automatic model_step(input bit irq_in, output int cyc, output bit ind,
                              output bit took_int, output string tag);
        logic [15:0] ins, v;
        logic [11:0] ea;
        ins = mm[mpc];
        mpc = mpc + 12'd1;
        cyc = 3;
        ea  = ins[11:0];
        ind = ins[15];
        if (ind) begin
            ea  = mm[ea][11:0];
            cyc += 3;
        end
        case (ins[14:12])
            3'b001: begin mr1 = mr1 + mm[ea]; cyc += 3; tag = "R5"; end
            3'b010: begin
                v = mm[ea] + 16'd1;
                mm[ea] = v;
                if (v == 16'd0) mpc = mpc + 12'd1;
                cyc += 4; tag = "R6";
            end
            3'b011: begin mm[ea] = {4'd0, mpc}; mpc = ea + 12'd1; cyc += 3; tag = "R7"; end
            default: begin cyc += 1; tag = "R8"; end
        endcase
        if (ind) tag = {tag, "/R4"};
        took_int = irq_in && mie;
        if (took_int) begin
            mm[0] = {4'd0, mpc};
            mpc = 12'd1;
            mie = 1'b0;
            cyc += 3;
            tag = {tag, "/R9"};
        end
    endtask

    function automatic bit legal_move(input logic [1:0] a, input logic [1:0] b);
        case (a)
            2'b00: return (b == 2'b01 || b == 2'b10);
            2'b01: return (b == 2'b10);
            2'b10: return (b == 2'b00 || b == 2'b11);
            default: return (b == 2'b00);
        endcase
    endfunction

    task automatic run(input int ninstr, input bit directed);
        int          cyc, cnt, bad_mem;
        bit          ind, took, saw_ind, saw_int, seq_bad, strobe_bad;
        string       tag;
        logic [1:0]  pph, pst;
        rst_n = 1'b0;
        irq = 1'b0;
        mpc = '0; mr1 = '0; mie = 1'b1;
        repeat (3) @(negedge clk);
        chk(pc_out == 12'd0 && r1_out == 16'd0, "R1", "pc/r1 after reset",
            {pc_out, r1_out}, 32'd0);
        chk(cyc_code == 2'b00 && step_idx == 2'd0, "R1", "phase/step after reset",
            {cyc_code, step_idx}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < ninstr; i++) begin
            chk(pc_out == mpc, "R3", "pc at instruction start", pc_out, mpc);
            chk(r1_out == mr1, "R5", "r1 at instruction start", r1_out, mr1);
            irq = directed ? (i >= 3) : ($urandom % 6 == 0);
            model_step(irq, cyc, ind, took, tag);
            cnt = 0; saw_ind = 0; saw_int = 0; seq_bad = 0; strobe_bad = 0;
            pph = cyc_code; pst = step_idx;
            do begin
                @(negedge clk);
                cnt++;
                if (mem_rd && mem_wr) strobe_bad = 1;
                if (cyc_code == 2'b01) saw_ind = 1;
                if (cyc_code == 2'b11) saw_int = 1;
                if (cyc_code != pph) begin
                    if (step_idx != 2'd0 || !legal_move(pph, cyc_code)) seq_bad = 1;
                end else if (step_idx != pst + 2'd1) begin
                    seq_bad = 1;
                end
                pph = cyc_code; pst = step_idx;
            end while (!(cyc_code == 2'b00 && step_idx == 2'd0) && cnt < 40);
            chk(cnt == cyc, tag, "cycles per instruction", cnt, cyc);
            chk(!seq_bad, "R2/R11", "phase and step sequence", seq_bad, 0);
            chk(!strobe_bad, "R10", "read and write strobes together", strobe_bad, 0);
            chk(saw_ind == ind, "R4", "indirect phase entered", saw_ind, ind);
            chk(saw_int == took, "R9", "interrupt phase entered", saw_int, took);
        end
        chk(pc_out == mpc && r1_out == mr1, "R3", "final pc/r1", {pc_out, r1_out}, {mpc, mr1});
        bad_mem = 0;
        for (int a = 0; a < 4096; a++)
            if (mem[a] !== mm[a]) bad_mem++;
        chk(bad_mem == 0, "R6/R7/R9", "memory words differing from model", bad_mem, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int a = 0; a < 4096; a++) put(a, 16'h0000);
        put(12'h000, 16'h2100);   // skip-if-zero on 0x100
        put(12'h001, 16'h1101);   // add 0x101
        put(12'h002, 16'h9102);   // add, indirect through 0x102
        put(12'h003, 16'h3200);   // branch and save to 0x200
        put(12'h100, 16'hFFFF);   // wraps to zero: skip taken
        put(12'h101, 16'h0007);
        put(12'h102, 16'h8103);   // pointer, only low 12 bits used
        put(12'h103, 16'h0005);
        put(12'h201, 16'h7000);   // unused opcode
        put(12'h202, 16'h4000);   // unused opcode
        run(10, 1'b1);
        for (int r = 0; r < 3; r++) begin
            for (int a = 0; a < 4096; a++) begin
                int sel;
                logic [2:0] op;
                sel = $urandom % 10;
                if (sel < 3)      op = 3'b001;
                else if (sel < 5) op = 3'b010;
                else if (sel < 7) op = 3'b011;
                else              op = 3'($urandom % 8) | 3'b100;
                if (sel == 9) op = 3'b000;
                put(a, {($urandom % 4 == 0), op, 12'($urandom)});
            end
            put(12'h050, 16'h2051);  // directed skip among random words
            put(12'h051, 16'hFFFF);
            run(300, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R2 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule